// File: doc/BRIEF.md
# Smart Card Slot Activation Sequencer

This block brings up a smart card slot once a card is inserted. It synchronises an active-high card-present input and waits for a programmable settle time so the slot mechanism can come to rest. It then drives an active-low power enable, starts a divided card clock, holds the card reset low for a fixed number of card clock cycles and releases it. After release it watches the card I/O line for the start of the Answer-to-Reset. The I/O line is only an input here: the block never drives it, so it stays in receive mode throughout.

If the answer does not start within a fixed number of card clock cycles, the block sets a sticky timeout flag and powers the slot down. It does the same when the card is removed at any point. The power-down order is always the same: reset low, then clock stopped, then power released. Status outputs show that reset has been released, that the answer has started, and that a timeout occurred. Both event flags clear when a new activation begins.

Top module: `sc_activation`

## Requirements
- R1: Out of reset and when idle: power enable high (off), card clock low, card reset low, and all three status outputs low. An asynchronous reset returns the block to this state at once.
- R2: A rising edge of the card-present input starts a settle wait of SETTLE_CYCLES system clocks. The input passes through a two-stage synchroniser, so power enable goes low exactly SETTLE_CYCLES+3 system clocks after the input rises. If card-present drops during the wait, the block returns to idle and never powers the slot.
- R3: The card clock runs only while power is enabled and is low whenever it is stopped. Its period is 2^sel system clocks for the select input sel; a select of 0 acts as 1.
- R4: Card reset stays low for RST_HOLD rising card clock edges after power is enabled (512 by default). It goes high together with the RST_HOLD-th rising edge.
- R5: The start of the Answer-to-Reset is the first falling edge of the synchronised I/O line while reset is released. This sets the answer-started flag, and power, clock and reset stay on. I/O activity while reset is still low is ignored.
- R6: If no answer start is seen within ATR_WAIT rising card clock edges after reset release (65536 by default), the block sets the sticky timeout flag and deactivates. Reset goes low together with the ATR_WAIT-th rising edge.
- R7: Deactivation, caused by card removal or by timeout, drives reset low in the first cycle, stops the clock in the next cycle, and releases power enable in the cycle after that.
- R8: After a timeout, the slot stays unpowered while the card remains present. Only a new rising edge of card-present starts activation again, and that restart clears both event flags.
- R9: The activation-done output is high exactly while card reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| card_present_i | input | 1 | Card present, active high, asynchronous |
| card_io_i | input | 1 | Card I/O line as received, asynchronous |
| clk_sel_i | input | SEL_W | Card clock divider select, period 2^sel |
| pwr_en_no | output | 1 | Slot power enable, active low |
| card_clk_o | output | 1 | Card clock |
| card_rst_no | output | 1 | Card reset, active low |
| act_done_o | output | 1 | Reset released, activation complete |
| atr_started_o | output | 1 | Answer-to-Reset start seen |
| atr_tmo_o | output | 1 | Sticky Answer-to-Reset timeout |

## Verification
A wrong sequencer state shows at the ports within one system clock, because power, clock gating and reset decode directly from the state register. The bench therefore checks each deactivation step at the exact sample where it should occur. An off-by-one in the shared cycle timer shifts power-on by one system clock, or shifts reset release and timeout by one card clock edge, so the bench counts system clocks and card clock rising edges exactly rather than within a window. A fault in the divider changes the measured clock period in the first two edges after power-on.

// File: rtl/sc_act_pkg.sv
package sc_act_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_RST_HOLD,
    ST_ATR_WAIT,
    ST_ACTIVE,
    ST_DOWN_RST,
    ST_DOWN_CLK
  } act_state_e;
endpackage

// File: rtl/sc_sync2.sv
module sc_sync2 #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RESET_VAL;
      q_o    <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/sc_clk_div.sv
module sc_clk_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             card_clk_o,
  output logic             rise_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] low_bits;
  logic [SEL_W-1:0] sel_eff;

  // select 0 is treated as 1: minimum period of two system clocks
  assign sel_eff  = (sel_i == '0) ? SEL_W'(1) : sel_i;
  assign mask     = (CNT_W'(1) << sel_eff) - CNT_W'(1);
  assign low_bits = cnt_q & mask;

  // rising edge of the card clock happens on the next system edge
  assign rise_o     = en_i && (low_bits == (mask >> 1));
  assign card_clk_o = en_i && cnt_q[sel_eff - SEL_W'(1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sc_act_fsm.sv
module sc_act_fsm
  import sc_act_pkg::*;
#(
  parameter int SETTLE_CYCLES = 400000,
  parameter int RST_HOLD      = 512,
  parameter int ATR_WAIT      = 65536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       present_i,
  input  logic       io_i,
  input  logic       tick_i,
  output act_state_e state_o,
  output logic       atr_started_o,
  output logic       atr_tmo_o
);
  localparam int HOLD_MAX = (RST_HOLD > ATR_WAIT) ? RST_HOLD : ATR_WAIT;
  localparam int CNT_MAX  = (SETTLE_CYCLES > HOLD_MAX) ? SETTLE_CYCLES : HOLD_MAX;
  localparam int TMR_W    = $clog2(CNT_MAX + 1);

  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYCLES - 1);
  localparam logic [TMR_W-1:0] HOLD_LAST   = TMR_W'(RST_HOLD - 1);
  localparam logic [TMR_W-1:0] WAIT_LAST   = TMR_W'(ATR_WAIT - 1);

  act_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             pres_q, io_q;
  logic             pres_rise, io_fall;

  assign pres_rise = present_i && !pres_q;
  assign io_fall   = io_q && !io_i;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      tmr_q         <= '0;
      pres_q        <= 1'b0;
      io_q          <= 1'b1;
      atr_started_o <= 1'b0;
      atr_tmo_o     <= 1'b0;
    end else begin
      pres_q <= present_i;
      io_q   <= io_i;
      unique case (state_q)
        ST_IDLE: begin
          if (pres_rise) begin
            state_q       <= ST_SETTLE;
            tmr_q         <= '0;
            atr_started_o <= 1'b0;
            atr_tmo_o     <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (!present_i) begin
            state_q <= ST_IDLE;
          end else if (tmr_q == SETTLE_LAST) begin
            state_q <= ST_RST_HOLD;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        ST_RST_HOLD: begin
          if (!present_i) begin
            state_q <= ST_DOWN_RST;
          end else if (tick_i) begin
            if (tmr_q == HOLD_LAST) begin
              state_q <= ST_ATR_WAIT;
              tmr_q   <= '0;
            end else begin
              tmr_q <= tmr_q + TMR_W'(1);
            end
          end
        end
        ST_ATR_WAIT: begin
          if (!present_i) begin
            state_q <= ST_DOWN_RST;
          end else if (io_fall) begin
            state_q       <= ST_ACTIVE;
            atr_started_o <= 1'b1;
          end else if (tick_i) begin
            if (tmr_q == WAIT_LAST) begin
              state_q   <= ST_DOWN_RST;
              atr_tmo_o <= 1'b1;
            end else begin
              tmr_q <= tmr_q + TMR_W'(1);
            end
          end
        end
        ST_ACTIVE: begin
          if (!present_i) state_q <= ST_DOWN_RST;
        end
        ST_DOWN_RST: state_q <= ST_DOWN_CLK;
        ST_DOWN_CLK: state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_activation.sv
module sc_activation
  import sc_act_pkg::*;
#(
  parameter int SETTLE_CYCLES = 400000,
  parameter int RST_HOLD      = 512,
  parameter int ATR_WAIT      = 65536,
  parameter int SEL_W         = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             card_present_i,
  input  logic             card_io_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  output logic             pwr_en_no,
  output logic             card_clk_o,
  output logic             card_rst_no,
  output logic             act_done_o,
  output logic             atr_started_o,
  output logic             atr_tmo_o
);
  logic       present_s, io_s, tick, clk_run;
  act_state_e state;

  sc_sync2 #(.RESET_VAL(1'b0)) u_sync_pres (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(card_present_i), .q_o(present_s)
  );

  sc_sync2 #(.RESET_VAL(1'b1)) u_sync_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(card_io_i), .q_o(io_s)
  );

  sc_clk_div #(.SEL_W(SEL_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(clk_run), .sel_i(clk_sel_i),
    .card_clk_o(card_clk_o), .rise_o(tick)
  );

  sc_act_fsm #(
    .SETTLE_CYCLES(SETTLE_CYCLES), .RST_HOLD(RST_HOLD), .ATR_WAIT(ATR_WAIT)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .present_i(present_s), .io_i(io_s),
    .tick_i(tick), .state_o(state), .atr_started_o(atr_started_o),
    .atr_tmo_o(atr_tmo_o)
  );

  always_comb begin
    clk_run     = 1'b0;
    pwr_en_no   = 1'b1;
    card_rst_no = 1'b0;
    unique case (state)
      ST_RST_HOLD, ST_DOWN_RST: begin
        clk_run   = 1'b1;
        pwr_en_no = 1'b0;
      end
      ST_ATR_WAIT, ST_ACTIVE: begin
        clk_run     = 1'b1;
        pwr_en_no   = 1'b0;
        card_rst_no = 1'b1;
      end
      ST_DOWN_CLK: pwr_en_no = 1'b0;
      default: ;
    endcase
  end

  assign act_done_o = (state == ST_ATR_WAIT) || (state == ST_ACTIVE);
endmodule

// File: rtl/sc_activation_chk.sv
module sc_activation_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_en_no,
  input logic card_clk_o,
  input logic card_rst_no,
  input logic act_done_o,
  input logic atr_started_o,
  input logic atr_tmo_o
);
  // R3
  clk_off_unpowered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_no |-> !card_clk_o);
  // R4
  rst_needs_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_no |-> !pwr_en_no);
  // R7
  power_drop_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_no) |-> (!$past(card_clk_o) && !$past(card_rst_no)));
  // R6
  timeout_deact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(atr_tmo_o) |-> (!card_rst_no && !atr_started_o));
  // R5
  atr_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(atr_started_o) |-> (card_rst_no && !pwr_en_no));
  // R9
  done_tracks_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_done_o == card_rst_no);
endmodule

bind sc_activation sc_activation_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_en_no(pwr_en_no), .card_clk_o(card_clk_o),
  .card_rst_no(card_rst_no), .act_done_o(act_done_o),
  .atr_started_o(atr_started_o), .atr_tmo_o(atr_tmo_o)
);

// File: tb/sc_activation_test.sv
module sc_activation_test;
  localparam int S  = 40;
  localparam int RH = 512;
  localparam int AW = 256;

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] atr_at;
    logic        glitch;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{sel: 3'd1, atr_at: 16'd0,   glitch: 1'b0},
    '{sel: 3'd1, atr_at: 16'd5,   glitch: 1'b0},
    '{sel: 3'd2, atr_at: 16'd100, glitch: 1'b1},
    '{sel: 3'd3, atr_at: 16'd0,   glitch: 1'b1},
    '{sel: 3'd0, atr_at: 16'd246, glitch: 1'b0},
    '{sel: 3'd2, atr_at: 16'd0,   glitch: 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, present = 1'b0, io = 1'b1;
  logic [2:0] sel = 3'd1;
  logic pwr_n, cclk, crst_n, done, atr, tmo;
  int checks = 0, fails = 0;
  logic prev_clk = 1'b0, rose = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sc_activation #(.SETTLE_CYCLES(S), .RST_HOLD(RH), .ATR_WAIT(AW), .SEL_W(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .card_present_i(present), .card_io_i(io),
    .clk_sel_i(sel), .pwr_en_no(pwr_n), .card_clk_o(cclk), .card_rst_no(crst_n),
    .act_done_o(done), .atr_started_o(atr), .atr_tmo_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rose = cclk && !prev_clk;
    prev_clk = cclk;
  endtask

  task automatic chk_idle(input string req);
    chk(pwr_n && !cclk && !crst_n && !done, req, "idle outputs {pwr,clk,rst,done}",
        {pwr_n, cclk, crst_n, done}, 4'b1000);
  endtask

  task automatic insert_measure(output int n);
    present = 1'b1;
    n = 0;
    do begin step(); n++; end while (pwr_n && n < S + 100);
  endtask

  // removal while active: reset low first, then clock stop, then power off
  task automatic remove_check_order();
    int lim = 0;
    present = 1'b0;
    do begin step(); lim++; end while (crst_n && lim < 20);
    chk(!crst_n && !pwr_n, "R7", "rst low while powered", pwr_n, 0);
    step();
    chk(!cclk && !pwr_n, "R7", "clock stopped before power off", {cclk, pwr_n}, 0);
    step();
    chk(pwr_n, "R7", "power released third", pwr_n, 1);
  endtask

  initial begin
    int n, t, rises, first, second, bad;
    bit seen_rst;
    repeat (3) step();
    chk_idle("R1");
    chk(!atr && !tmo, "R1", "flags after reset", {atr, tmo}, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk_idle("R1");

    for (int v = 0; v < NV; v++) begin
      int per;
      sel = VEC[v].sel;
      per = 1 << ((VEC[v].sel == 3'd0) ? 1 : VEC[v].sel);
      io = 1'b1;
      repeat (2) step();
      chk_idle("R1");
      insert_measure(n);
      chk(n == S + 3, "R2", "settle cycles", n, S + 3);
      chk(!tmo && !atr, "R8", "flags cleared on restart", {atr, tmo}, 0);

      rises = 0; t = 0; first = -1; second = -1;
      while (!crst_n && t < RH * per + 100) begin
        step(); t++;
        if (VEC[v].glitch && t == 3) io = 1'b0;
        if (t == 9) io = 1'b1;
        if (rose) begin
          rises++;
          if (first < 0) first = t; else if (second < 0) second = t;
        end
      end
      chk(rises == RH, "R4", "card clocks before reset release", rises, RH);
      chk(second - first == per, "R3", "card clock period", second - first, per);
      chk(done && !atr, "R9", "done at release, no early ATR (R5)", {done, atr}, 2);

      if (VEC[v].atr_at != 0) begin
        rises = 0;
        while (rises < int'(VEC[v].atr_at)) begin step(); if (rose) rises++; end
        io = 1'b0;
        repeat (4 * per) step();
        chk(atr && !tmo && !pwr_n && crst_n, "R5", "ATR start seen, slot on",
            {atr, tmo, pwr_n, crst_n}, 4'b1001);
        repeat ((AW + 4) * per) step();
        chk(!tmo && !pwr_n && crst_n, "R6", "no timeout after ATR", {tmo, pwr_n, crst_n}, 3'b001);
        io = 1'b1;
        remove_check_order();
      end else begin
        rises = 0; t = 0;
        do begin step(); t++; if (rose) rises++; end while (crst_n && t < AW * per + 100);
        chk(rises == AW, "R6", "card clocks to timeout", rises, AW);
        chk(tmo && !pwr_n && !crst_n, "R7", "timeout drops rst first", {tmo, pwr_n, crst_n}, 3'b100);
        step();
        chk(!cclk && !pwr_n, "R7", "clock stops second", {cclk, pwr_n}, 0);
        step();
        chk(pwr_n, "R7", "power off third", pwr_n, 1);
        bad = 0;
        repeat (200) begin step(); if (!pwr_n) bad++; end
        chk(bad == 0 && tmo, "R8", "no restart while present, sticky flag", bad, 0);
        present = 1'b0;
      end
      repeat (5) step();
      chk_idle("R1");
    end

    // removal during settle: never powers
    present = 1'b1;
    repeat (10) step();
    present = 1'b0;
    bad = 0;
    repeat (S + 20) begin step(); if (!pwr_n || cclk) bad++; end
    chk(bad == 0, "R2", "abort during settle keeps slot off", bad, 0);

    // removal during reset hold
    sel = 3'd1;
    insert_measure(n);
    chk(n == S + 3, "R2", "settle after abort", n, S + 3);
    repeat (30) step();
    present = 1'b0;
    seen_rst = 1'b0; t = 0;
    do begin step(); t++; if (crst_n) seen_rst = 1'b1; end while (!pwr_n && t < 20);
    chk(!seen_rst && pwr_n && !cclk, "R7", "removal in reset hold", {seen_rst, pwr_n, cclk}, 3'b010);

    // async reset in the middle of activation
    repeat (3) step();
    insert_measure(n);
    repeat (20) step();
    rst_n = 1'b0;
    #1;
    chk(pwr_n && !cclk && !crst_n, "R1", "async reset mid activation",
        {pwr_n, cclk, crst_n}, 3'b100);
    present = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (2) step();
    chk_idle("R1");

    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule